// File: doc/BRIEF.md
# Shared Memory Ownership Arbiter

This block decides which of two masters reaches a single byte-wide memory: a host that accesses it indirectly through a port, or a target processor that sees the memory on its cartridge bus. Ownership is not negotiated. A control bit set by host software picks the owner, and the other side is shut out. The block also drives three active-low control lines towards the target: halt, interrupt request and non-maskable interrupt. Each line follows its own control bit.

The memory sits outside the block and is synchronous, with a read latency of one cycle. The target presents a 16-bit address. Only addresses whose top bit is 0 reach the 32K array, and the lower 15 bits index it. Every other target read returns 0xFF. A write-protect bit makes the memory read-only from the target side. Host writes are not affected by it.

The host request side is a valid/ready stream. `host_ready` is high only while the host owns the memory. A request is accepted in a cycle where `host_valid` and `host_ready` are both high. A held request waits through back-pressure until ownership passes to the host. Read data comes back with `host_rvalid` exactly one cycle after acceptance, and it cannot be stalled. The target side uses plain strobes. Read data appears on `tgt_rdata` in the cycle after `tgt_rd`.

Top module: `shmem_arbiter`

## Requirements
- R1: While the ownership bit `ctl_v` has been 0 at the last clock edge, the target owns the memory: `host_ready` is 0 and a host request causes no memory strobe.
- R2: While `ctl_v` has been 1 at the last clock edge, the host owns the memory. `host_ready` is 1 and an accepted host write strobes `mem_we`. An accepted host read gives `host_rvalid` = 1 with the stored byte on `host_rdata` one cycle later.
- R3: With write-protect `ctl_w` = 1, a target write produces no `mem_we`. Target reads still return the stored byte.
- R4: `ctl_w` has no effect on host writes or host reads.
- R5: A target access with address bit 15 = 1 reaches no memory: a read returns 0xFF and a write produces no `mem_we`. With bit 15 = 0, bits 14..0 appear unchanged on `mem_addr`.
- R6: While the host owns the memory, a target read returns 0xFF and a target write is dropped. The stored byte is unchanged.
- R7: `tgt_halt_n`, `tgt_irq_n` and `tgt_nmi_n` are driven low one cycle after `ctl_h`, `ctl_i` and `ctl_n` respectively go to 1. Each returns high one cycle after its bit clears.
- R8: A change of `ctl_v` changes ownership at the next clock edge. A read issued by the previous owner before that edge still returns its data.
- R9: After reset the target owns the memory, all three target control lines are high, and no memory strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_v | input | 1 | Ownership select: 1 = host, 0 = target |
| ctl_w | input | 1 | Target write-protect |
| ctl_h | input | 1 | Request target halt |
| ctl_i | input | 1 | Request target interrupt |
| ctl_n | input | 1 | Request target non-maskable interrupt |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Host request accepted when high |
| host_we | input | 1 | Host request is a write |
| host_addr | input | 15 | Host memory address |
| host_wdata | input | 8 | Host write data |
| host_rvalid | output | 1 | Host read data valid |
| host_rdata | output | 8 | Host read data |
| tgt_addr | input | 16 | Target bus address |
| tgt_wdata | input | 8 | Target write data |
| tgt_rd | input | 1 | Target read strobe |
| tgt_wr | input | 1 | Target write strobe |
| tgt_rdata | output | 8 | Target read data, valid the cycle after `tgt_rd` |
| mem_addr | output | 15 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Memory read data, one cycle after `mem_re` |
| tgt_halt_n | output | 1 | Target halt, active low |
| tgt_irq_n | output | 1 | Target interrupt request, active low |
| tgt_nmi_n | output | 1 | Target non-maskable interrupt, active low |

## Verification
The memory path is driven with both owners, and each owner issues both reads and writes. Each access runs with write-protect on and off, and target addresses are taken both inside and above the populated window. These combinations separate a blocked or dropped access from a granted one. They also show that write-protect masks only target writes, and that a read from outside the window yields 0xFF and not stale memory data. Directed sequences hand ownership over during an outstanding target read, which shows the registered switch point and that the earlier read still completes. They also toggle each control line alone to expose its one-cycle delay and its polarity.

// File: rtl/shmem_arb_pkg.sv
package shmem_arb_pkg;
  typedef enum logic {
    OWN_TGT  = 1'b0,
    OWN_HOST = 1'b1
  } owner_e;

  localparam int LINE_HALT = 0;
  localparam int LINE_IRQ  = 1;
  localparam int LINE_NMI  = 2;
  localparam int LINE_CNT  = 3;
endpackage

// File: rtl/shmem_owner_reg.sv
module shmem_owner_reg
  import shmem_arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sel_host,
  output owner_e owner
);
  // Ownership changes only at a clock edge; reset hands the memory to the target.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner <= OWN_TGT;
    else        owner <= sel_host ? OWN_HOST : OWN_TGT;
  end
endmodule

// File: rtl/shmem_tgt_port.sv
module shmem_tgt_port
  import shmem_arb_pkg::*;
#(
  parameter int          TGT_AW = 16,
  parameter int          MEM_AW = 15,
  parameter int          DW     = 8,
  parameter logic [DW-1:0] FILL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  owner_e            owner,
  input  logic              wprot,
  input  logic [TGT_AW-1:0] tgt_addr,
  input  logic [DW-1:0]     tgt_wdata,
  input  logic              tgt_rd,
  input  logic              tgt_wr,
  input  logic [DW-1:0]     mem_rdata,
  output logic              req_re,
  output logic              req_we,
  output logic [MEM_AW-1:0] req_addr,
  output logic [DW-1:0]     req_wdata,
  output logic [DW-1:0]     tgt_rdata
);
  logic in_window;
  logic granted;
  logic hit_q;

  generate
    if (TGT_AW > MEM_AW) begin : g_decode
      assign in_window = (tgt_addr[TGT_AW-1:MEM_AW] == '0);
    end else begin : g_full
      assign in_window = 1'b1;
    end
  endgenerate

  assign granted   = (owner == OWN_TGT);
  assign req_re    = granted && in_window && tgt_rd;
  assign req_we    = granted && in_window && tgt_wr && !tgt_rd && !wprot;
  assign req_addr  = tgt_addr[MEM_AW-1:0];
  assign req_wdata = tgt_wdata;

  // Remember whether the previous cycle's read really hit the memory; this
  // follows the read, not the owner, so a handover cannot cut it short.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= req_re;
  end

  assign tgt_rdata = hit_q ? mem_rdata : FILL;
endmodule

// File: rtl/shmem_host_port.sv
module shmem_host_port
  import shmem_arb_pkg::*;
#(
  parameter int MEM_AW = 15,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  owner_e            owner,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic              host_we,
  input  logic [MEM_AW-1:0] host_addr,
  input  logic [DW-1:0]     host_wdata,
  input  logic [DW-1:0]     mem_rdata,
  output logic              host_rvalid,
  output logic [DW-1:0]     host_rdata,
  output logic              req_re,
  output logic              req_we,
  output logic [MEM_AW-1:0] req_addr,
  output logic [DW-1:0]     req_wdata
);
  logic fire;
  logic rvalid_q;

  assign host_ready = (owner == OWN_HOST);
  assign fire       = host_valid && host_ready;
  assign req_re     = fire && !host_we;
  assign req_we     = fire && host_we;
  assign req_addr   = host_addr;
  assign req_wdata  = host_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid_q <= 1'b0;
    else        rvalid_q <= req_re;
  end

  assign host_rvalid = rvalid_q;
  assign host_rdata  = rvalid_q ? mem_rdata : '0;
endmodule

// File: rtl/shmem_ctl_lines.sv
module shmem_ctl_lines #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] assert_req,
  output logic [N-1:0] line_n
);
  generate
    for (genvar k = 0; k < N; k++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_n[k] <= 1'b1;
        else        line_n[k] <= !assert_req[k];
      end
    end
  endgenerate
endmodule

// File: rtl/shmem_arbiter.sv
module shmem_arbiter
  import shmem_arb_pkg::*;
#(
  parameter int TGT_AW = 16,
  parameter int MEM_AW = 15,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_v,
  input  logic              ctl_w,
  input  logic              ctl_h,
  input  logic              ctl_i,
  input  logic              ctl_n,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic              host_we,
  input  logic [MEM_AW-1:0] host_addr,
  input  logic [DW-1:0]     host_wdata,
  output logic              host_rvalid,
  output logic [DW-1:0]     host_rdata,
  input  logic [TGT_AW-1:0] tgt_addr,
  input  logic [DW-1:0]     tgt_wdata,
  input  logic              tgt_rd,
  input  logic              tgt_wr,
  output logic [DW-1:0]     tgt_rdata,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [DW-1:0]     mem_rdata,
  output logic              tgt_halt_n,
  output logic              tgt_irq_n,
  output logic              tgt_nmi_n
);
  owner_e owner;

  logic              t_re, t_we, h_re, h_we;
  logic [MEM_AW-1:0] t_addr, h_addr;
  logic [DW-1:0]     t_wdata, h_wdata;
  logic [LINE_CNT-1:0] line_req, line_n;

  shmem_owner_reg u_owner (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_host (ctl_v),
    .owner    (owner)
  );

  shmem_tgt_port #(.TGT_AW(TGT_AW), .MEM_AW(MEM_AW), .DW(DW)) u_tgt (
    .clk       (clk),
    .rst_n     (rst_n),
    .owner     (owner),
    .wprot     (ctl_w),
    .tgt_addr  (tgt_addr),
    .tgt_wdata (tgt_wdata),
    .tgt_rd    (tgt_rd),
    .tgt_wr    (tgt_wr),
    .mem_rdata (mem_rdata),
    .req_re    (t_re),
    .req_we    (t_we),
    .req_addr  (t_addr),
    .req_wdata (t_wdata),
    .tgt_rdata (tgt_rdata)
  );

  shmem_host_port #(.MEM_AW(MEM_AW), .DW(DW)) u_host (
    .clk         (clk),
    .rst_n       (rst_n),
    .owner       (owner),
    .host_valid  (host_valid),
    .host_ready  (host_ready),
    .host_we     (host_we),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .mem_rdata   (mem_rdata),
    .host_rvalid (host_rvalid),
    .host_rdata  (host_rdata),
    .req_re      (h_re),
    .req_we      (h_we),
    .req_addr    (h_addr),
    .req_wdata   (h_wdata)
  );

  // Memory side: the owner's request path goes to the memory.
  always_comb begin
    if (owner == OWN_HOST) begin
      mem_addr  = h_addr;
      mem_wdata = h_wdata;
      mem_we    = h_we;
      mem_re    = h_re;
    end else begin
      mem_addr  = t_addr;
      mem_wdata = t_wdata;
      mem_we    = t_we;
      mem_re    = t_re;
    end
  end

  always_comb begin
    line_req            = '0;
    line_req[LINE_HALT] = ctl_h;
    line_req[LINE_IRQ]  = ctl_i;
    line_req[LINE_NMI]  = ctl_n;
  end

  shmem_ctl_lines #(.N(LINE_CNT)) u_lines (
    .clk        (clk),
    .rst_n      (rst_n),
    .assert_req (line_req),
    .line_n     (line_n)
  );

  assign tgt_halt_n = line_n[LINE_HALT];
  assign tgt_irq_n  = line_n[LINE_IRQ];
  assign tgt_nmi_n  = line_n[LINE_NMI];
endmodule

// File: rtl/shmem_arbiter_chk.sv
module shmem_arbiter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_v,
  input logic        ctl_w,
  input logic        ctl_h,
  input logic        ctl_n,
  input logic        host_valid,
  input logic        host_ready,
  input logic        host_we,
  input logic        host_rvalid,
  input logic [15:0] tgt_addr,
  input logic        tgt_rd,
  input logic        tgt_wr,
  input logic [7:0]  tgt_rdata,
  input logic        mem_we,
  input logic        tgt_halt_n,
  input logic        tgt_nmi_n
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_tgt_owns_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(ctl_v)) |-> !host_ready);

  assert_host_owns_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(ctl_v)) |-> host_ready);

  assert_host_read_returns_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_ready && !host_we) |=> host_rvalid);

  assert_wprot_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(ctl_v) && mem_we) |-> !ctl_w);

  assert_out_of_window_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_rd && tgt_addr[15]) |=> (tgt_rdata == 8'hFF));

  assert_out_of_window_nowrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_wr && tgt_addr[15] && !host_ready) |-> !mem_we);

  assert_halt_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (tgt_halt_n == !$past(ctl_h)));

  assert_nmi_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (tgt_nmi_n == !$past(ctl_n)));
endmodule

bind shmem_arbiter shmem_arbiter_chk u_chk (.*);

// File: tb/shmem_arbiter_test.sv
`timescale 1ns/1ps
module shmem_arbiter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        ctl_v = 0, ctl_w = 0, ctl_h = 0, ctl_i = 0, ctl_n = 0;
  logic        host_valid = 0, host_we = 0;
  logic [14:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_ready, host_rvalid;
  logic [7:0]  host_rdata;
  logic [15:0] tgt_addr = '0;
  logic [7:0]  tgt_wdata = '0;
  logic        tgt_rd = 0, tgt_wr = 0;
  logic [7:0]  tgt_rdata;
  logic [14:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we, mem_re;
  logic [7:0]  mem_rdata = '0;
  logic        tgt_halt_n, tgt_irq_n, tgt_nmi_n;

  shmem_arbiter uut (.*);

  // Memory model: synchronous, one cycle of read latency, 1024 bytes aliased.
  logic [7:0] mem [0:1023];
  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[9:0]];
  end

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [3:0]  req;
    logic        v, w, host, we;
    logic [15:0] addr;
    logic [7:0]  wdata;
    logic        exp_str;
    logic        chk_rd;
    logic [7:0]  exp_rd;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{4'd2, 1'b0,1'b0,1'b0,1'b1, 16'h0010, 8'h5A, 1'b1, 1'b0, 8'h00}, // R2 tgt write in window
    '{4'd2, 1'b0,1'b0,1'b0,1'b0, 16'h0010, 8'h00, 1'b1, 1'b1, 8'h5A}, // R2 tgt read back
    '{4'd3, 1'b0,1'b1,1'b0,1'b1, 16'h0010, 8'h11, 1'b0, 1'b0, 8'h00}, // R3 protected write dropped
    '{4'd3, 1'b0,1'b1,1'b0,1'b0, 16'h0010, 8'h00, 1'b1, 1'b1, 8'h5A}, // R3 read still works
    '{4'd5, 1'b0,1'b0,1'b0,1'b1, 16'h8010, 8'h22, 1'b0, 1'b0, 8'h00}, // R5 write above window
    '{4'd5, 1'b0,1'b0,1'b0,1'b0, 16'h8010, 8'h00, 1'b0, 1'b1, 8'hFF}, // R5 read above window
    '{4'd2, 1'b1,1'b0,1'b1,1'b1, 16'h0020, 8'h33, 1'b1, 1'b0, 8'h00}, // R2 host write
    '{4'd4, 1'b1,1'b1,1'b1,1'b1, 16'h0021, 8'h44, 1'b1, 1'b0, 8'h00}, // R4 host write under W
    '{4'd4, 1'b1,1'b1,1'b1,1'b0, 16'h0021, 8'h00, 1'b1, 1'b1, 8'h44}, // R4 host read under W
    '{4'd6, 1'b1,1'b0,1'b0,1'b0, 16'h0010, 8'h00, 1'b0, 1'b1, 8'hFF}, // R6 tgt read blocked
    '{4'd6, 1'b1,1'b0,1'b0,1'b1, 16'h0010, 8'h66, 1'b0, 1'b0, 8'h00}, // R6 tgt write blocked
    '{4'd6, 1'b1,1'b0,1'b1,1'b0, 16'h0010, 8'h00, 1'b1, 1'b1, 8'h5A}, // R6 byte unchanged
    '{4'd1, 1'b0,1'b0,1'b1,1'b1, 16'h0020, 8'h77, 1'b0, 1'b0, 8'h00}, // R1 host blocked
    '{4'd1, 1'b0,1'b0,1'b0,1'b0, 16'h0020, 8'h00, 1'b1, 1'b1, 8'h33}  // R1 host write never landed
  };

  task automatic idle();
    host_valid = 0; host_we = 0; tgt_rd = 0; tgt_wr = 0;
  endtask

  task automatic run_vec(input vec_t vv);
    string rq;
    rq = $sformatf("R%0d", vv.req);
    @(posedge clk); #1;
    idle();
    ctl_v = vv.v; ctl_w = vv.w;
    @(posedge clk); #1;
    if (vv.host) begin
      host_valid = 1; host_we = vv.we; host_addr = vv.addr[14:0]; host_wdata = vv.wdata;
    end else begin
      tgt_rd = !vv.we; tgt_wr = vv.we; tgt_addr = vv.addr; tgt_wdata = vv.wdata;
    end
    @(negedge clk);
    check(rq, "mem strobe", {15'd0, mem_we | mem_re}, {15'd0, vv.exp_str});
    if (vv.host) check(rq, "host_ready", {15'd0, host_ready}, {15'd0, vv.v});
    @(posedge clk); #1;
    idle();
    @(negedge clk);
    if (vv.chk_rd) begin
      if (vv.host) begin
        check(rq, "host_rvalid", {15'd0, host_rvalid}, 16'd1);
        check(rq, "host_rdata", {8'd0, host_rdata}, {8'd0, vv.exp_rd});
      end else begin
        check(rq, "tgt_rdata", {8'd0, tgt_rdata}, {8'd0, vv.exp_rd});
      end
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    check("R9", "halt_n", {15'd0, tgt_halt_n}, 16'd1);
    check("R9", "irq_n",  {15'd0, tgt_irq_n},  16'd1);
    check("R9", "nmi_n",  {15'd0, tgt_nmi_n},  16'd1);
    check("R9", "mem strobes", {14'd0, mem_we, mem_re}, 16'd0);
    check("R9", "host_ready", {15'd0, host_ready}, 16'd0);
    rst_n = 1;

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R5: low bits pass straight to the memory address
    @(posedge clk); #1;
    ctl_v = 0; ctl_w = 0;
    @(posedge clk); #1;
    tgt_wr = 1; tgt_addr = 16'h7ABC; tgt_wdata = 8'hC3;
    @(negedge clk);
    check("R5", "mem_addr", {1'b0, mem_addr}, 16'h7ABC);
    check("R5", "mem_wdata", {8'd0, mem_wdata}, 16'h00C3);
    @(posedge clk); #1;
    idle();

    // R8: handover during an outstanding target read
    @(posedge clk); #1;
    tgt_rd = 1; tgt_addr = 16'h0010; ctl_v = 1;
    @(negedge clk);
    check("R8", "mem_re before edge", {15'd0, mem_re}, 16'd1);
    check("R8", "host_ready before edge", {15'd0, host_ready}, 16'd0);
    @(posedge clk); #1;
    idle();
    @(negedge clk);
    check("R8", "tgt_rdata completes", {8'd0, tgt_rdata}, 16'h005A);
    check("R8", "host_ready after edge", {15'd0, host_ready}, 16'd1);
    @(posedge clk); #1;
    ctl_v = 0;

    // R7: control lines, one cycle delay, active low
    @(posedge clk); #1;
    ctl_h = 1;
    @(negedge clk);
    check("R7", "halt_n before edge", {15'd0, tgt_halt_n}, 16'd1);
    @(negedge clk);
    check("R7", "halt_n asserted", {15'd0, tgt_halt_n}, 16'd0);
    check("R7", "irq_n idle", {15'd0, tgt_irq_n}, 16'd1);
    @(posedge clk); #1;
    ctl_h = 0; ctl_i = 1;
    @(negedge clk); @(negedge clk);
    check("R7", "irq_n asserted", {15'd0, tgt_irq_n}, 16'd0);
    check("R7", "halt_n released", {15'd0, tgt_halt_n}, 16'd1);
    @(posedge clk); #1;
    ctl_i = 0; ctl_n = 1;
    @(negedge clk); @(negedge clk);
    check("R7", "nmi_n asserted", {15'd0, tgt_nmi_n}, 16'd0);
    check("R7", "irq_n released", {15'd0, tgt_irq_n}, 16'd1);
    @(posedge clk); #1;
    ctl_n = 0;
    @(negedge clk); @(negedge clk);
    check("R7", "nmi_n released", {15'd0, tgt_nmi_n}, 16'd1);

    finish_run();
  end
endmodule